// File: doc/BRIEF.md
# Eight-Line Programmable Interrupt Controller

This block collects eight interrupt request lines, ranks them by a fixed priority, and raises a single interrupt output toward a processor. Software programs it through two byte-wide ports chosen by one address bit. The control port (`addr_sel` = 0) takes a setup-start word and two runtime command words, which are told apart by data bits 4 and 3. The data port (`addr_sel` = 1) carries the remaining setup words and then the mask register. The setup-start word always restarts programming, whatever state the block is in.

When the processor acknowledges, the block returns an 8-bit vector made from a programmed base and the winning line number. It also marks that line as in service, unless automatic end-of-interrupt is on. Software can instead poll the block through a read. It can retire service levels in non-specific or specific form, and it can pick whether control-port reads show the request register or the in-service register. A special mask mode lets masked in-service levels stop blocking lower-priority lines.

Top module: `pic8_ctrl`

## Requirements
- R1: A control-port write with data bit 4 set starts setup. It clears the mask, the in-service register, special mask mode, a pending poll and auto-EOI, and it sets the read select to the request register. It stores bit 3 (1 = level-sensitive, 0 = edge-sensitive), bit 1 (1 = single, so the link word is skipped) and bit 0 (1 = mode word follows). Until setup completes, control-port writes with bit 4 clear are ignored.
- R2: After the setup-start word, data-port writes are taken in this order: the base word (bits 7:3 become the vector base), then the link word unless single was chosen, then the mode word if bit 0 asked for it. In the mode word, bit 1 enables auto-EOI. Data-port writes after that go to the mask.
- R3: Once setup is complete, data-port reads and writes access the mask. Mask bit n set keeps line n from raising `int_req` or winning a grant. It does not stop the request from being recorded.
- R4: In edge mode, a line that was low at one clock edge and is high at the next sets its request bit at that second edge. The bit stays set until the line is granted. In level mode, the request register copies the lines with one clock of delay.
- R5: Priority is fixed, with line 0 highest. `int_req` is high exactly when some unmasked request exists and its lowest index is below the lowest index among in-service bits (with special mask mode on, in-service bits of masked lines do not count).
- R6: An `int_ack` pulse in a cycle where `int_req` is high grants the winning line. From the next cycle, `vec_out` = {base, 3-bit line number}, the line's in-service bit is set, and in edge mode its request bit is cleared. With `int_req` low, `vec_out` becomes {base, 7} and no register changes.
- R7: With auto-EOI enabled, a grant leaves the in-service register unchanged.
- R8: A control-port write with bits 4:3 = 00 is an EOI command when bit 5 is set. With bit 6 set, it clears the in-service bit named by bits 2:0. With bit 6 clear, it clears the lowest-index set in-service bit. Writes of this form with bit 5 clear leave the in-service register unchanged.
- R9: A control-port write with bits 4:3 = 01 and bit 1 set picks what later control-port reads return: in-service (bit 0 = 1) or request (bit 0 = 0). With bit 1 clear, the selection is kept.
- R10: A bits 4:3 = 01 write with bit 2 set makes only the next control-port read return {pending, 0000, line}, where pending equals `int_req` and line is 0 when nothing is pending. That read grants the line exactly as `int_ack` does.
- R11: A bits 4:3 = 01 write with bits 6:5 = 11 turns special mask mode on, and with bits 6:5 = 10 turns it off.
- R12: After reset, the block is ready with the mask clear, base 0, edge mode, auto-EOI off, read select on the request register, `int_req` low and `vec_out` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_sel | input | 1 | Port select: 0 control, 1 data |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe; a poll is consumed at the clock edge it spans |
| rd_data | output | 8 | Read data, combinational |
| irq_in | input | 8 | Interrupt request lines, synchronous to clk |
| int_req | output | 1 | Interrupt to the processor |
| int_ack | input | 1 | Acknowledge pulse |
| vec_out | output | 8 | Vector of the last acknowledge |

## Verification
The bench uses the package defaults of eight lines and an 8-bit data path. With these values, every level from 0 to 7 can be reached, including line 7, whose vector has the same low bits as the no-pending answer. The 3-bit level field exactly fills the bits below the 5-bit base. Random base, mask and request patterns then drive full drain sequences through both the acknowledge path and the poll path, so every mask pattern and every priority order can occur.

// File: rtl/pic8_pkg.sv
package pic8_pkg;
  localparam int DW     = 8;
  localparam int LINES  = 8;
  localparam int LVL_W  = $clog2(LINES);
  localparam int BASE_W = DW - LVL_W;

  // command-word bit positions (decoded by software, so fixed)
  localparam int B_START  = 4;
  localparam int B_KIND   = 3;
  localparam int B_LEVEL  = 3;
  localparam int B_SINGLE = 1;
  localparam int B_NEED4  = 0;
  localparam int B_AUTO   = 1;
  localparam int B_EOI    = 5;
  localparam int B_SPEC   = 6;
  localparam int B_RSELEN = 1;
  localparam int B_RSEL   = 0;
  localparam int B_POLL   = 2;
  localparam int B_SMMEN  = 6;
  localparam int B_SMM    = 5;

  typedef enum logic [1:0] {SEQ_READY, SEQ_BASE, SEQ_LINK, SEQ_MODE} seq_t;

  // lowest set index = highest priority; 0 when empty
  function automatic logic [LVL_W-1:0] first_lvl(input logic [LINES-1:0] v);
    logic [LVL_W-1:0] l;
    l = '0;
    for (int i = LINES - 1; i >= 0; i--) begin
      if (v[i]) l = LVL_W'(i);
    end
    return l;
  endfunction

  function automatic logic [LINES-1:0] lvl_bit(input logic [LVL_W-1:0] l);
    return LINES'(1) << l;
  endfunction

  function automatic logic [DW-1:0] make_vec(input logic [BASE_W-1:0] b,
                                             input logic [LVL_W-1:0] l);
    return {b, l};
  endfunction

  function automatic logic [DW-1:0] make_poll(input logic hit,
                                              input logic [LVL_W-1:0] l);
    return {hit, {(DW - 1 - LVL_W){1'b0}}, l};
  endfunction
endpackage

// File: rtl/pic8_cmd_decode.sv
module pic8_cmd_decode
  import pic8_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_sel,
  input  logic              wr_en,
  input  logic [DW-1:0]     wr_data,
  input  logic              poll_taken,
  output logic [LINES-1:0]  mask_q,
  output logic [BASE_W-1:0] base_q,
  output logic              level_q,
  output logic              auto_q,
  output logic              rsel_q,
  output logic              smm_q,
  output logic              poll_q,
  output logic              init_start,
  output logic              eoi_cmd,
  output logic              eoi_spec,
  output logic [LVL_W-1:0]  eoi_lvl
);
  seq_t seq_q;
  logic single_q, need4_q;
  logic busy, ctl_wr, dat_wr, op2_wr, op3_wr;

  always_comb begin
    busy       = (seq_q != SEQ_READY);
    ctl_wr     = wr_en && !addr_sel;
    dat_wr     = wr_en && addr_sel;
    init_start = ctl_wr && wr_data[B_START];
    op2_wr     = ctl_wr && !wr_data[B_START] && !wr_data[B_KIND] && !busy;
    op3_wr     = ctl_wr && !wr_data[B_START] &&  wr_data[B_KIND] && !busy;
    eoi_cmd    = op2_wr && wr_data[B_EOI];
    eoi_spec   = wr_data[B_SPEC];
    eoi_lvl    = wr_data[LVL_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seq_q    <= SEQ_READY;
      mask_q   <= '0;
      base_q   <= '0;
      level_q  <= 1'b0;
      auto_q   <= 1'b0;
      rsel_q   <= 1'b0;
      smm_q    <= 1'b0;
      poll_q   <= 1'b0;
      single_q <= 1'b1;
      need4_q  <= 1'b0;
    end else begin
      if (poll_taken) poll_q <= 1'b0;
      if (init_start) begin
        seq_q    <= SEQ_BASE;
        mask_q   <= '0;
        level_q  <= wr_data[B_LEVEL];
        single_q <= wr_data[B_SINGLE];
        need4_q  <= wr_data[B_NEED4];
        auto_q   <= 1'b0;
        rsel_q   <= 1'b0;
        smm_q    <= 1'b0;
        poll_q   <= 1'b0;
      end else if (dat_wr) begin
        unique case (seq_q)
          SEQ_READY: mask_q <= wr_data[LINES-1:0];
          SEQ_BASE: begin
            base_q <= wr_data[DW-1:LVL_W];
            if (!single_q)    seq_q <= SEQ_LINK;
            else if (need4_q) seq_q <= SEQ_MODE;
            else              seq_q <= SEQ_READY;
          end
          SEQ_LINK: seq_q <= need4_q ? SEQ_MODE : SEQ_READY;
          SEQ_MODE: begin
            auto_q <= wr_data[B_AUTO];
            seq_q  <= SEQ_READY;
          end
          default: seq_q <= SEQ_READY;
        endcase
      end
      if (op3_wr) begin
        if (wr_data[B_RSELEN]) rsel_q <= wr_data[B_RSEL];
        if (wr_data[B_POLL])   poll_q <= 1'b1;
        if (wr_data[B_SMMEN])  smm_q  <= wr_data[B_SMM];
      end
    end
  end
endmodule

// File: rtl/pic8_req_capture.sv
module pic8_req_capture
  import pic8_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] irq_in,
  input  logic             level_mode,
  input  logic [LINES-1:0] grant_clr,
  output logic [LINES-1:0] req_q
);
  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic prev_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        prev_q   <= 1'b0;
        req_q[g] <= 1'b0;
      end else begin
        prev_q <= irq_in[g];
        if (level_mode) req_q[g] <= irq_in[g];
        else            req_q[g] <= (req_q[g] && !grant_clr[g]) || (irq_in[g] && !prev_q);
      end
    end
  end
endmodule

// File: rtl/pic8_service.sv
module pic8_service
  import pic8_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINES-1:0]  req,
  input  logic [LINES-1:0]  mask,
  input  logic              smm,
  input  logic              auto_eoi,
  input  logic [BASE_W-1:0] base,
  input  logic              init_start,
  input  logic              eoi_cmd,
  input  logic              eoi_spec,
  input  logic [LVL_W-1:0]  eoi_lvl,
  input  logic              ack,
  input  logic              poll_take,
  output logic [LINES-1:0]  srv_q,
  output logic              int_pend,
  output logic [LVL_W-1:0]  win_lvl,
  output logic              grant,
  output logic [LINES-1:0]  grant_clr,
  output logic [DW-1:0]     vec_q
);
  logic [LINES-1:0] cand, block, eoi_clr, srv_set;
  logic [LVL_W-1:0] blk_lvl;

  always_comb begin
    cand      = req & ~mask;
    block     = srv_q & ~(smm ? mask : '0);
    win_lvl   = first_lvl(cand);
    blk_lvl   = first_lvl(block);
    int_pend  = (|cand) && (!(|block) || (win_lvl < blk_lvl));
    grant     = (ack || poll_take) && int_pend;
    grant_clr = grant ? lvl_bit(win_lvl) : '0;
    srv_set   = (grant && !auto_eoi) ? lvl_bit(win_lvl) : '0;
    eoi_clr   = '0;
    if (eoi_cmd) eoi_clr = eoi_spec ? lvl_bit(eoi_lvl) : lvl_bit(first_lvl(srv_q));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      srv_q <= '0;
      vec_q <= '0;
    end else begin
      if (init_start) srv_q <= '0;
      else            srv_q <= (srv_q & ~eoi_clr) | srv_set;
      if (ack) vec_q <= make_vec(base, int_pend ? win_lvl : LVL_W'(LINES - 1));
    end
  end
endmodule

// File: rtl/pic8_ctrl.sv
module pic8_ctrl
  import pic8_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             addr_sel,
  input  logic             wr_en,
  input  logic [DW-1:0]    wr_data,
  input  logic             rd_en,
  output logic [DW-1:0]    rd_data,
  input  logic [LINES-1:0] irq_in,
  output logic             int_req,
  input  logic             int_ack,
  output logic [DW-1:0]    vec_out
);
  logic [LINES-1:0]  mask_w, req_w, srv_w, gclr_w;
  logic [BASE_W-1:0] base_w;
  logic              level_w, auto_w, rsel_w, smm_w, poll_w;
  logic              init_start_w, eoi_w, eoi_spec_w, poll_rd_w, grant_w, pend_w;
  logic [LVL_W-1:0]  eoi_lvl_w, win_w;

  assign poll_rd_w = rd_en && !addr_sel && poll_w;

  pic8_cmd_decode u_dec (
    .clk(clk), .rst_n(rst_n), .addr_sel(addr_sel), .wr_en(wr_en),
    .wr_data(wr_data), .poll_taken(poll_rd_w), .mask_q(mask_w),
    .base_q(base_w), .level_q(level_w), .auto_q(auto_w), .rsel_q(rsel_w),
    .smm_q(smm_w), .poll_q(poll_w), .init_start(init_start_w),
    .eoi_cmd(eoi_w), .eoi_spec(eoi_spec_w), .eoi_lvl(eoi_lvl_w)
  );

  pic8_req_capture u_req (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .level_mode(level_w),
    .grant_clr(gclr_w), .req_q(req_w)
  );

  pic8_service u_srv (
    .clk(clk), .rst_n(rst_n), .req(req_w), .mask(mask_w), .smm(smm_w),
    .auto_eoi(auto_w), .base(base_w), .init_start(init_start_w),
    .eoi_cmd(eoi_w), .eoi_spec(eoi_spec_w), .eoi_lvl(eoi_lvl_w),
    .ack(int_ack), .poll_take(poll_rd_w), .srv_q(srv_w), .int_pend(pend_w),
    .win_lvl(win_w), .grant(grant_w), .grant_clr(gclr_w), .vec_q(vec_out)
  );

  always_comb begin
    if (addr_sel)    rd_data = mask_w;
    else if (poll_w) rd_data = make_poll(pend_w, pend_w ? win_w : '0);
    else if (rsel_w) rd_data = srv_w;
    else             rd_data = req_w;
  end

  assign int_req = pend_w;
endmodule

// File: rtl/pic8_chk.sv
module pic8_chk
  import pic8_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              int_req,
  input logic              int_ack,
  input logic [DW-1:0]     vec_out,
  input logic              init_start,
  input logic              grant,
  input logic [LVL_W-1:0]  win_lvl,
  input logic [LINES-1:0]  srv,
  input logic [LINES-1:0]  mask,
  input logic [BASE_W-1:0] base,
  input logic              auto_eoi,
  input logic              smm
);
  // R1
  setup_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_start |=> (srv == '0 && mask == '0));

  // R6
  grant_marks_srv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && !auto_eoi && !init_start) |=> srv[$past(win_lvl)]);

  // R7
  auto_no_growth_chk: assert property (@(posedge clk) disable iff (!rst_n)
    auto_eoi |=> ($countones(srv) <= $countones($past(srv))));

  // R5
  no_req_under_srv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int_req && !smm) |-> (((srv & ~(LINES'('1) << win_lvl)) == '0) && !srv[win_lvl]));

  // R6
  vec_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int_ack |=> (vec_out[DW-1:LVL_W] == $past(base)));
endmodule

bind pic8_ctrl pic8_chk u_chk (
  .clk(clk), .rst_n(rst_n), .int_req(int_req), .int_ack(int_ack),
  .vec_out(vec_out), .init_start(init_start_w), .grant(grant_w),
  .win_lvl(win_w), .srv(srv_w), .mask(mask_w), .base(base_w),
  .auto_eoi(auto_w), .smm(smm_w)
);

// File: tb/pic8_ctrl_tb_top.sv
module pic8_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       addr_sel = 1'b0, wr_en = 1'b0, rd_en = 1'b0, int_ack = 1'b0;
  logic [7:0] wr_data = '0, irq_in = '0;
  logic [7:0] rd_data, vec_out;
  logic       int_req;
  int         n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  pic8_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .addr_sel(addr_sel), .wr_en(wr_en),
    .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data), .irq_in(irq_in),
    .int_req(int_req), .int_ack(int_ack), .vec_out(vec_out)
  );

  function automatic logic [2:0] exp_first(input logic [7:0] p);
    for (int i = 0; i < 8; i++) if (p[i]) return 3'(i);
    return 3'd0;
  endfunction

  function automatic logic [7:0] exp_vec(input logic [7:0] b, input logic [2:0] l);
    return {b[7:3], l};
  endfunction

  task automatic chk(input string r, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk); addr_sel = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] v);
    @(negedge clk); addr_sel = a; rd_en = 1'b1;
    #2 v = rd_data;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic ack(output logic [7:0] v);
    @(negedge clk); int_ack = 1'b1;
    @(negedge clk); int_ack = 1'b0; v = vec_out;
  endtask

  task automatic pulse(input logic [7:0] p);
    @(negedge clk); irq_in = p;
    @(negedge clk); irq_in = '0;
  endtask

  task automatic rd_srv(output logic [7:0] v);
    wr(1'b0, 8'h0B); rd(1'b0, v);
  endtask

  task automatic rd_req(output logic [7:0] v);
    wr(1'b0, 8'h0A); rd(1'b0, v);
  endtask

  task automatic drain();
    logic [7:0] v;
    wr(1'b1, 8'h00);
    repeat (9) begin
      if (int_req) begin ack(v); wr(1'b0, 8'h20); end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk("R12 int_req", {7'b0, int_req}, 8'h00);
    chk("R12 vec_out", vec_out, 8'h00);
    rd(1'b1, v); chk("R12 mask", v, 8'h00);

    // R2 cascade with mode word, auto-EOI on
    wr(1'b0, 8'h11); wr(1'b1, 8'h48); wr(1'b1, 8'h04); wr(1'b1, 8'h02);
    wr(1'b1, 8'hAA);
    rd(1'b1, v); chk("R2 R3 mask after full setup", v, 8'hAA);
    pulse(8'h04);
    chk("R3 unmasked line raises", {7'b0, int_req}, 8'h01);
    ack(v); chk("R6 vector", v, 8'h4A);
    rd_srv(v); chk("R7 auto-EOI keeps srv", v, 8'h00);
    pulse(8'h02);
    chk("R3 masked line quiet", {7'b0, int_req}, 8'h00);
    rd_req(v); chk("R3 R4 masked still recorded", v, 8'h02);

    // R1 R2 single, no mode word
    wr(1'b0, 8'h12); wr(1'b1, 8'h20);
    chk("R1 mask cleared lets line 1 through", {7'b0, int_req}, 8'h01);
    ack(v); chk("R6 vector line1", v, 8'h21);
    wr(1'b0, 8'h20);
    pulse(8'h20); ack(v); chk("R6 vector line5", v, 8'h25);
    rd_srv(v); chk("R6 srv set", v, 8'h20);
    pulse(8'h40);
    chk("R5 lower blocked", {7'b0, int_req}, 8'h00);
    pulse(8'h08);
    chk("R5 higher nests", {7'b0, int_req}, 8'h01);
    ack(v); chk("R6 vector line3", v, 8'h23);
    rd_req(v); chk("R4 edge cleared on grant", v, 8'h40);
    rd_srv(v); chk("R6 nested srv", v, 8'h28);
    wr(1'b0, 8'h20); rd(1'b0, v); chk("R8 nonspecific", v, 8'h20);
    wr(1'b0, 8'h65); rd(1'b0, v); chk("R8 specific", v, 8'h00);
    chk("R5 line6 now free", {7'b0, int_req}, 8'h01);
    ack(v); chk("R6 vector line6", v, 8'h26);
    wr(1'b0, 8'h46); wr(1'b0, 8'h80);
    rd(1'b0, v); chk("R8 no EOI bit no effect", v, 8'h40);
    pulse(8'h10);
    wr(1'b1, 8'h40);
    wr(1'b0, 8'h12); wr(1'b0, 8'h0B); wr(1'b1, 8'h20);
    rd(1'b1, v); chk("R1 mask cleared", v, 8'h00);
    rd(1'b0, v); chk("R1 R9 select reset, op ignored in setup", v, 8'h10);
    rd_srv(v); chk("R1 srv cleared", v, 8'h00);

    // R6 spurious
    wr(1'b1, 8'hFF);
    ack(v); chk("R6 spurious vector", v, 8'h27);
    rd_srv(v); chk("R6 spurious no srv", v, 8'h00);
    wr(1'b1, 8'h00);

    // R10 poll
    pulse(8'h02);
    wr(1'b0, 8'h0C); rd(1'b0, v); chk("R10 poll line1", v, 8'h81);
    rd_srv(v); chk("R10 poll grants", v, 8'h02);
    wr(1'b0, 8'h20);
    wr(1'b0, 8'h0C); rd(1'b0, v); chk("R10 poll line4", v, 8'h84);
    wr(1'b0, 8'h20);
    wr(1'b1, 8'h04); pulse(8'h04);
    wr(1'b0, 8'h0E); rd(1'b0, v); chk("R10 poll none", v, 8'h00);
    rd(1'b0, v); chk("R10 R9 one-shot then request", v, 8'h04);
    wr(1'b1, 8'h00); ack(v); chk("R6 vector line2", v, 8'h22);
    wr(1'b0, 8'h20);

    // R11 special mask mode
    pulse(8'h10); ack(v); chk("R6 vector line4", v, 8'h24);
    pulse(8'h40);
    chk("R11 blocked before", {7'b0, int_req}, 8'h00);
    wr(1'b1, 8'h10); wr(1'b0, 8'h68);
    chk("R11 on unblocks", {7'b0, int_req}, 8'h01);
    wr(1'b0, 8'h48);
    chk("R11 off blocks", {7'b0, int_req}, 8'h00);
    wr(1'b0, 8'h64); wr(1'b1, 8'h00);
    ack(v); chk("R6 vector line6 after SMM", v, 8'h26);
    wr(1'b0, 8'h20);

    // R4 level mode
    wr(1'b0, 8'h1A); wr(1'b1, 8'h30);
    @(negedge clk); irq_in = 8'h01;
    @(negedge clk);
    chk("R4 level raises", {7'b0, int_req}, 8'h01);
    ack(v); chk("R6 level vector", v, 8'h30);
    rd_req(v); chk("R4 level follows line", v, 8'h01);
    chk("R5 own srv blocks", {7'b0, int_req}, 8'h00);
    wr(1'b0, 8'h20);
    chk("R4 level re-raises", {7'b0, int_req}, 8'h01);
    @(negedge clk); irq_in = 8'h00;
    @(negedge clk);
    chk("R4 level drops", {7'b0, int_req}, 8'h00);

    // random patterns
    for (int it = 0; it < 40; it++) begin
      logic [7:0] b, mk, p, left;
      logic [2:0] l;
      b = 8'($urandom); mk = 8'($urandom); p = 8'($urandom);
      wr(1'b0, 8'h12); wr(1'b1, b);
      drain();
      wr(1'b1, mk);
      pulse(p);
      rd_req(v); chk("R4 random capture", v, p);
      left = p & ~mk;
      while (left != 0) begin
        l = exp_first(left);
        chk("R5 random pending", {7'b0, int_req}, 8'h01);
        if (it % 2 == 1) begin
          wr(1'b0, 8'h0C); rd(1'b0, v); chk("R10 random poll", v, {5'b10000, l});
        end else begin
          ack(v); chk("R6 random vector", v, exp_vec(b, l));
        end
        wr(1'b0, 8'h20);
        left[l] = 1'b0;
      end
      chk("R3 R5 random quiet", {7'b0, int_req}, 8'h00);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule